// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the byte-wide register interface of an eight-line programmable interrupt controller. It sits between a host write/read port and the priority core. Host writes arrive at one of two byte offsets. The block turns them into a multi-word setup sequence or into run-time command words. It holds the resulting configuration: trigger style, single or cascaded operation, vector base, cascade map or slave identity, mode flags and the mask. The priority core reads this configuration directly.

Reads at offset 0 return either the pending-request byte or the in-service byte. Both bytes are supplied by the priority core, and a command word picks which one is returned. Reads at offset 1 return the mask. A specific end-of-interrupt command makes the block emit a one-cycle pulse with a line number, which tells the core to retire that line. Whether the block acts as master or slave is fixed by a parameter. That role decides how the third setup word is stored.

Top module: `pic_prog_if`

## Requirements
- R1: After reset the mask is 0, the setup sequencer is idle (`init_busy_o`=0), `eoi_o` is 0, and offset-0 reads return the request byte.
- R2: `rd_data_o` is combinational. When `addr_i`=1 it shows the mask. When `addr_i`=0 it shows `irr_i` if the read select is "request", and `isr_i` otherwise.
- R3: A write to offset 0 with data bit 4 set starts setup. It clears the mask and captures three fields: bit 3 as edge trigger (1) or level trigger (0), bit 1 as single (1) or cascade (0), and bit 0 as "fourth word follows". The sequencer then waits for the second word.
- R4: The second word (an offset-1 write) sets the vector base to data bits 7:3 with bits 2:0 forced to zero. In single mode this word also clears the cascade byte and ends setup. In cascade mode the sequencer waits for the third word.
- R5: On a master (`IS_MASTER`=1), the third word is stored in full as the cascade byte.
- R6: On a slave (`IS_MASTER`=0), only bits 2:0 of the third word are stored, and the upper cascade bits are zero. After the third word, setup waits for the fourth word if bit 0 of the first word was set, and otherwise ends.
- R7: The fourth word captures four fields: bit 4 as special nesting, bits 3:2 as buffer mode, bit 1 as auto-EOI and bit 0 as processor mode. It then ends setup.
- R8: When the sequencer is idle, an offset-1 write loads the mask with the data.
- R9: An offset-0 write with bits 4:3=00 and bits 7:5=011 produces `eoi_o`=1 for exactly the cycle after the write. During that cycle `eoi_line_o` equals data bits 2:0.
- R10: An offset-0 write with bits 4:3=00 and any other code in bits 7:5 produces no pulse and changes no output.
- R11: An offset-0 write with bits 4:3=01 and bit 1 set selects the offset-0 read source: bit 0 = 1 selects the request byte, 0 selects the in-service byte. If bit 1 is clear, the selection is kept.
- R12: A setup-start write that arrives while setup is already in progress restarts the sequence from the second word.
- R13: Command words at offset 0 (R9, R11) are processed while setup is in progress, and they do not move the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 1 | Byte offset |
| wr_data_i | input | 8 | Write data |
| irr_i | input | 8 | Pending-request byte from the core |
| isr_i | input | 8 | In-service byte from the core |
| rd_data_o | output | 8 | Read data for `addr_i` |
| mask_o | output | 8 | Mask byte |
| edge_mode_o | output | 1 | 1 = edge trigger, 0 = level trigger |
| single_mode_o | output | 1 | 1 = single, 0 = cascade |
| vec_base_o | output | 8 | Vector base, low 3 bits zero |
| casc_map_o | output | 8 | Slave bitmap (master) or slave ID (slave) |
| nest_mode_o | output | 1 | Special nesting flag |
| buf_mode_o | output | 2 | Buffer mode field |
| auto_eoi_o | output | 1 | Auto-EOI flag |
| cpu_mode_o | output | 1 | Processor mode flag |
| init_busy_o | output | 1 | Setup sequence in progress |
| eoi_o | output | 1 | Specific end-of-interrupt pulse |
| eoi_line_o | output | 3 | Line being retired |

## Verification
Two functions of the block can fall in the same cycle: a command word at offset 0 (a specific end-of-interrupt or a read-select change) and an unfinished setup sequence. The bench provokes this by starting setup, issuing an end-of-interrupt and a read-select command before the second word, and then finishing the sequence. It judges the result by three observations: the pulse and its line number, the read source seen at offset 0, and the following offset-1 words, which must still land in the vector base and the cascade byte rather than the mask. Random traffic mixes all write kinds on top of this, and every output is compared with a bench model after each write.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;
  localparam int DW = 8;
  localparam int LINE_W = $clog2(DW);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_e;

  typedef struct packed {
    logic edge_trig;
    logic single;
    logic want_w4;
  } head_t;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_prog_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] mask_o,
  output logic          edge_mode_o,
  output logic          single_mode_o,
  output logic [DW-1:0] vec_base_o,
  output logic [DW-1:0] casc_map_o,
  output logic          nest_mode_o,
  output logic [1:0]    buf_mode_o,
  output logic          auto_eoi_o,
  output logic          cpu_mode_o,
  output logic          init_busy_o
);
  seq_e            state_q;
  head_t           head_q;
  logic [DW-1:0]   mask_q, vec_q, casc_q;
  logic            nest_q, aeoi_q, cpu_q;
  logic [1:0]      buf_q;

  logic start_w, port1_w;
  assign start_w = wr_en_i && !addr_i && wr_data_i[4];
  assign port1_w = wr_en_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      head_q  <= '0;
      mask_q  <= '0;
      vec_q   <= '0;
      casc_q  <= '0;
      nest_q  <= 1'b0;
      buf_q   <= '0;
      aeoi_q  <= 1'b0;
      cpu_q   <= 1'b0;
    end else if (start_w) begin
      mask_q            <= '0;
      head_q.edge_trig  <= wr_data_i[3];
      head_q.single     <= wr_data_i[1];
      head_q.want_w4    <= wr_data_i[0];
      state_q           <= SEQ_W2;
    end else if (port1_w) begin
      unique case (state_q)
        SEQ_IDLE: mask_q <= wr_data_i;
        SEQ_W2: begin
          vec_q <= {wr_data_i[DW-1:LINE_W], LINE_W'(0)};
          if (head_q.single) begin
            casc_q  <= '0;
            state_q <= SEQ_IDLE;
          end else begin
            state_q <= SEQ_W3;
          end
        end
        SEQ_W3: begin
          if (IS_MASTER) casc_q <= wr_data_i;
          else           casc_q <= DW'(wr_data_i[LINE_W-1:0]);
          state_q <= head_q.want_w4 ? SEQ_W4 : SEQ_IDLE;
        end
        SEQ_W4: begin
          nest_q  <= wr_data_i[4];
          buf_q   <= wr_data_i[3:2];
          aeoi_q  <= wr_data_i[1];
          cpu_q   <= wr_data_i[0];
          state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mask_o        = mask_q;
  assign edge_mode_o   = head_q.edge_trig;
  assign single_mode_o = head_q.single;
  assign vec_base_o    = vec_q;
  assign casc_map_o    = casc_q;
  assign nest_mode_o   = nest_q;
  assign buf_mode_o    = buf_q;
  assign auto_eoi_o    = aeoi_q;
  assign cpu_mode_o    = cpu_q;
  assign init_busy_o   = (state_q != SEQ_IDLE);

  // R3
  start_clears_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[4]) |=> (mask_o == '0) && init_busy_o);
  // R8
  idle_mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && !init_busy_o) |=> (mask_o == $past(wr_data_i)) && !init_busy_o);
  // R4
  vec_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_base_o[LINE_W-1:0] == '0));
  // R6
  slave_id_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_MASTER) |-> (casc_map_o[DW-1:LINE_W] == '0));
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              eoi_o,
  output logic [LINE_W-1:0] eoi_line_o,
  output logic              rd_irr_o
);
  localparam logic [2:0] SUB_SPEC_EOI = 3'b011;

  logic cmd2_w, cmd3_w, spec_w;
  assign cmd2_w = wr_en_i && !addr_i && (wr_data_i[4:3] == 2'b00);
  assign cmd3_w = wr_en_i && !addr_i && (wr_data_i[4:3] == 2'b01);
  assign spec_w = cmd2_w && (wr_data_i[7:5] == SUB_SPEC_EOI);

  logic              eoi_q, rd_irr_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_q    <= 1'b0;
      line_q   <= '0;
      rd_irr_q <= 1'b1;
    end else begin
      eoi_q <= spec_w;
      if (spec_w) line_q <= wr_data_i[LINE_W-1:0];
      if (cmd3_w && wr_data_i[1]) rd_irr_q <= wr_data_i[0];
    end
  end

  assign eoi_o      = eoi_q;
  assign eoi_line_o = line_q;
  assign rd_irr_o   = rd_irr_q;

  // R9
  eoi_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[4:3] == 2'b00 && wr_data_i[7:5] == 3'b011)
      |=> eoi_o && (eoi_line_o == $past(wr_data_i[LINE_W-1:0])));
  // R9
  eoi_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o && !(wr_en_i && !addr_i)) |=> !eoi_o);
  // R10
  other_sub_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[4:3] == 2'b00 && wr_data_i[7:5] != 3'b011) |=> !eoi_o);
  // R11
  rdsel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[4:3] == 2'b01 && !wr_data_i[1]) |=> $stable(rd_irr_o));
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
  import pic_prog_pkg::*;
(
  input  logic          addr_i,
  input  logic          rd_irr_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] rd_data_o
);
  always_comb begin
    if (addr_i)        rd_data_o = mask_i;
    else if (rd_irr_i) rd_data_o = irr_i;
    else               rd_data_o = isr_i;
  end
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
  import pic_prog_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [DW-1:0]     irr_i,
  input  logic [DW-1:0]     isr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [DW-1:0]     mask_o,
  output logic              edge_mode_o,
  output logic              single_mode_o,
  output logic [DW-1:0]     vec_base_o,
  output logic [DW-1:0]     casc_map_o,
  output logic              nest_mode_o,
  output logic [1:0]        buf_mode_o,
  output logic              auto_eoi_o,
  output logic              cpu_mode_o,
  output logic              init_busy_o,
  output logic              eoi_o,
  output logic [LINE_W-1:0] eoi_line_o
);
  logic rd_irr;

  pic_init_seq #(.IS_MASTER(IS_MASTER)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i,
    .mask_o, .edge_mode_o, .single_mode_o, .vec_base_o, .casc_map_o,
    .nest_mode_o, .buf_mode_o, .auto_eoi_o, .cpu_mode_o, .init_busy_o
  );

  pic_cmd_dec u_cmd (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i,
    .eoi_o, .eoi_line_o, .rd_irr_o(rd_irr)
  );

  pic_rd_mux u_rd (
    .addr_i, .rd_irr_i(rd_irr), .irr_i, .isr_i, .mask_i(mask_o), .rd_data_o
  );

  // R13
  cmd_keeps_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && !wr_data_i[4]) |=> $stable(init_busy_o) && $stable(mask_o));
endmodule

// File: tb/pic_prog_if_tb.sv
module pic_prog_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] irr = '0, isr = '0;

  logic [7:0] m_rd, m_mask, m_vec, m_casc;
  logic       m_edge, m_single, m_nest, m_aeoi, m_cpu, m_busy, m_eoi;
  logic [1:0] m_buf;
  logic [2:0] m_line;
  logic [7:0] s_rd, s_mask, s_vec, s_casc;
  logic       s_edge, s_single, s_nest, s_aeoi, s_cpu, s_busy, s_eoi;
  logic [1:0] s_buf;
  logic [2:0] s_line;

  always #5 clk = ~clk;

  pic_prog_if #(.IS_MASTER(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .irr_i(irr), .isr_i(isr), .rd_data_o(m_rd), .mask_o(m_mask), .edge_mode_o(m_edge),
    .single_mode_o(m_single), .vec_base_o(m_vec), .casc_map_o(m_casc),
    .nest_mode_o(m_nest), .buf_mode_o(m_buf), .auto_eoi_o(m_aeoi), .cpu_mode_o(m_cpu),
    .init_busy_o(m_busy), .eoi_o(m_eoi), .eoi_line_o(m_line));

  pic_prog_if #(.IS_MASTER(1'b0)) u_slv (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .irr_i(irr), .isr_i(isr), .rd_data_o(s_rd), .mask_o(s_mask), .edge_mode_o(s_edge),
    .single_mode_o(s_single), .vec_base_o(s_vec), .casc_map_o(s_casc),
    .nest_mode_o(s_nest), .buf_mode_o(s_buf), .auto_eoi_o(s_aeoi), .cpu_mode_o(s_cpu),
    .init_busy_o(s_busy), .eoi_o(s_eoi), .eoi_line_o(s_line));

  int n_cmp = 0, n_bad = 0;

  // bench model
  int         e_step;  // 0 idle, 2/3/4 waiting for that word
  logic [7:0] e_mask, e_vec, e_casc_m, e_casc_s;
  logic       e_edge, e_single, e_w4, e_nest, e_aeoi, e_cpu, e_rdirr, e_eoi;
  logic [1:0] e_buf;
  logic [2:0] e_line;

  task automatic model_reset();
    e_step = 0; e_mask = 0; e_vec = 0; e_casc_m = 0; e_casc_s = 0;
    e_edge = 0; e_single = 0; e_w4 = 0; e_nest = 0; e_aeoi = 0; e_cpu = 0;
    e_buf = 0; e_rdirr = 1; e_eoi = 0; e_line = 0;
  endtask

  task automatic model_wr(input logic a, input logic [7:0] d);
    e_eoi = 0;
    if (!a) begin
      if (d[4]) begin
        e_mask = 0; e_edge = d[3]; e_single = d[1]; e_w4 = d[0]; e_step = 2;
      end else if (d[3] == 1'b0) begin
        if (d[7:5] == 3'b011) begin e_eoi = 1; e_line = d[2:0]; end
      end else if (d[1]) e_rdirr = d[0];
    end else begin
      case (e_step)
        0: e_mask = d;
        2: begin
          e_vec = d & 8'hF8;
          if (e_single) begin e_casc_m = 0; e_casc_s = 0; e_step = 0; end
          else e_step = 3;
        end
        3: begin
          e_casc_m = d; e_casc_s = {5'b0, d[2:0]};
          e_step = e_w4 ? 4 : 0;
        end
        default: begin
          e_nest = d[4]; e_buf = d[3:2]; e_aeoi = d[1]; e_cpu = d[0]; e_step = 0;
        end
      endcase
    end
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_rd(input string req);
    for (int a = 0; a < 2; a++) begin
      addr = a[0];
      #1;
      chk(req, "rd master", m_rd, a[0] ? e_mask : (e_rdirr ? irr : isr));
      chk(req, "rd slave", s_rd, a[0] ? e_mask : (e_rdirr ? irr : isr));
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "mask", m_mask, e_mask);
    chk(req, "edge", {7'b0, m_edge}, {7'b0, e_edge});
    chk(req, "single", {7'b0, m_single}, {7'b0, e_single});
    chk(req, "vec", m_vec, e_vec);
    chk(req, "casc master", m_casc, e_casc_m);
    chk(req, "casc slave", s_casc, e_casc_s);
    chk(req, "flags", {2'b0, m_nest, m_buf, m_aeoi, m_cpu, m_busy},
        {2'b0, e_nest, e_buf, e_aeoi, e_cpu, (e_step != 0)});
    chk(req, "eoi", {7'b0, m_eoi}, {7'b0, e_eoi});
    if (e_eoi) chk(req, "eoi line", {5'b0, m_line}, {5'b0, e_line});
    chk(req, "slave mask", s_mask, e_mask);
  endtask

  // drive on falling edge, write taken on next rising edge, checked on next falling edge
  task automatic wr(input logic a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    irr = 8'($urandom); isr = 8'($urandom);
    chk_all(req);
    chk_rd(req);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irr = 8'hA5; isr = 8'h3C;
    chk_all("R1");
    chk_rd("R1");

    // R8 idle mask load, R2 reads
    wr(1'b1, 8'h5A, "R8");
    // R3 + R4 single mode: base low bits dropped, setup ends
    wr(1'b1, 8'hFF, "R8");
    wr(1'b0, 8'h1A, "R3");  // edge, single, no fourth word
    wr(1'b1, 8'h6F, "R4");
    wr(1'b1, 8'h81, "R8");
    // R5/R6/R7 cascade with fourth word
    wr(1'b0, 8'h11, "R3");  // level, cascade, fourth word
    wr(1'b1, 8'h47, "R4");
    wr(1'b1, 8'hCD, "R5");
    wr(1'b1, 8'h1F, "R7");
    wr(1'b1, 8'h22, "R8");
    // R6 no fourth word: after third word, mask path again
    wr(1'b0, 8'h18, "R3");
    wr(1'b1, 8'h08, "R4");
    wr(1'b1, 8'hF6, "R6");
    wr(1'b1, 8'h77, "R6");
    // R12 restart mid sequence
    wr(1'b0, 8'h11, "R12");
    wr(1'b1, 8'h30, "R12");
    wr(1'b0, 8'h13, "R12");
    wr(1'b1, 8'h99, "R12");
    chk("R12", "base after restart", m_vec, 8'h98);
    // R13 commands during setup
    wr(1'b0, 8'h11, "R13");
    wr(1'b0, 8'h65, "R13");  // specific EOI line 5
    chk("R9", "eoi pulse", {7'b0, m_eoi}, 8'h01);
    @(negedge clk);
    chk("R9", "pulse width", {7'b0, m_eoi}, 8'h00);
    wr(1'b0, 8'h0A, "R13");  // read in-service
    wr(1'b1, 8'hE8, "R13");
    wr(1'b1, 8'h3C, "R13");
    wr(1'b1, 8'h02, "R13");
    chk("R13", "mask untouched", m_mask, 8'h00);
    // R11 hold and reselect
    wr(1'b0, 8'h09, "R11");
    wr(1'b0, 8'h0B, "R11");
    // R10 other sub-codes
    for (int c = 0; c < 8; c++)
      if (c != 3) wr(1'b0, {c[2:0], 5'b00110}, "R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      int k;
      d = 8'($urandom);
      k = $urandom % 8;
      case (k)
        0:       wr(1'b0, d | 8'h10, "R3");
        1, 2:    wr(1'b0, {d[7:5], 2'b00, d[2:0]}, "R9");
        3:       wr(1'b0, {d[7:5], 2'b01, d[2:0]}, "R11");
        default: wr(1'b1, d, "R8");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule